// File: doc/BRIEF.md
# Framed Register-Access Job Initiator

This block is the host end of a small register-access link that runs over byte streams. A local client gives it one command at a time: read or write, a 4-bit register address and, for a write, a data byte. The block turns the command into a framed job on an 8-bit outbound stream. The stream has valid/accept handshaking and flags that mark the first and last beat of a frame. The block then takes the framed acknowledge from a matching inbound stream. It returns the read byte, the target's error status and a protocol-error indication to the client, and signals the end of the job with a one-cycle done pulse.

Only one job is outstanding at a time. While a job is in flight the local port reports busy and ignores further commands. The block checks each acknowledge beat against the shape expected for the command it sent. A wrong header echo, misplaced flags, an early end of frame or a footer value other than 0x00 or 0x01 is reported as a protocol error when the job completes. The error and read-data outputs hold their values until the next job finishes.

Top module: `regjob_initiator`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `tx_valid`, `tx_first`, `tx_last`, `rx_accept` and `rsp_done` are 0 and `cmd_ready` is 1. This holds even if reset arrives in the middle of a job.
- R2: The header byte that is sent carries the command code in bits 3:0 (0 = read, 1 = write) and the address in bits 7:4.
- R3: A read job is sent as one beat: the header, with `tx_first` and `tx_last` both 1.
- R4: A write job is sent as two beats. The first is the header with `tx_first`=1 and `tx_last`=0. The second is the write data byte with `tx_first`=0 and `tx_last`=1.
- R5: While `tx_valid` is 1 and `tx_accept` is 0, `tx_valid`, `tx_first`, `tx_last` and `tx_data` keep their values on the next cycle. A beat moves only on a cycle where `tx_valid` and `tx_accept` are both 1.
- R6: `cmd_ready` is 1 only when no job is outstanding. A command taken in an idle cycle puts the header on the outbound stream in the next cycle. Commands offered while busy are ignored and leave the frame in progress unchanged.
- R7: `rx_accept` is 1 exactly while the block waits for an acknowledge beat, and is never 1 while an outbound beat is valid or while the block is idle.
- R8: An acknowledge to a read has three beats: the echoed header with first set, the data byte with no flags, then the footer with last set. An acknowledge to a write has two beats: the echo, then the footer. `rsp_done` rises in the cycle after the beat with last set is accepted. For a read, `rsp_rdata` then equals the data byte; for a write it is 0.
- R9: `rsp_err` is 1 at done when the footer byte is 0x01, and 0 when it is 0x00.
- R10: `rsp_proto_err` is 1 at done if any acknowledge beat broke the expected shape. This covers an echo different from the sent header, wrong first/last flags, an early last beat, or a footer other than 0x00/0x01. It only changes together with `rsp_done`.
- R11: `rsp_done` is high for exactly one cycle per completed job, and `cmd_ready` is 1 in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Local command offered |
| cmd_ready | output | 1 | Block idle, command taken when valid |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 4 | Register address |
| cmd_wdata | input | 8 | Write data |
| rsp_done | output | 1 | One-cycle job completion pulse |
| rsp_rdata | output | 8 | Read data of the last job (0 for writes) |
| rsp_err | output | 1 | Target reported error in footer |
| rsp_proto_err | output | 1 | Acknowledge frame malformed |
| tx_data | output | 8 | Outbound stream byte |
| tx_valid | output | 1 | Outbound beat valid |
| tx_first | output | 1 | Outbound beat starts frame |
| tx_last | output | 1 | Outbound beat ends frame |
| tx_accept | input | 1 | Outbound beat taken by target |
| rx_data | input | 8 | Inbound stream byte |
| rx_valid | input | 1 | Inbound beat valid |
| rx_first | input | 1 | Inbound beat starts frame |
| rx_last | input | 1 | Inbound beat ends frame |
| rx_accept | output | 1 | Block ready for an inbound beat |

## Verification
The assertions check on every cycle the properties that hold in every state. These are: outbound beats stay stable while stalled, flags appear only on a valid beat, busy excludes new commands, outbound valid and inbound accept never overlap, the write frame has its data beat, done follows a last beat and is a single pulse, and a protocol error appears only with done. The contents of each frame and the read-back values are checked only by the bench's scenarios, which play the target with a model register file. Those scenarios sweep every address for both commands with varied stalls and gaps, and inject malformed acknowledges (bad echo, odd footer, early end) to show the protocol-error and footer-error reporting.

// File: rtl/regjob_initiator.sv
module regjob_initiator #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  output logic                cmd_ready,
  input  logic                cmd_write,
  input  logic [DATA_W/2-1:0] cmd_addr,
  input  logic [DATA_W-1:0]   cmd_wdata,
  output logic                rsp_done,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                rsp_err,
  output logic                rsp_proto_err,
  output logic [DATA_W-1:0]   tx_data,
  output logic                tx_valid,
  output logic                tx_first,
  output logic                tx_last,
  input  logic                tx_accept,
  input  logic [DATA_W-1:0]   rx_data,
  input  logic                rx_valid,
  input  logic                rx_first,
  input  logic                rx_last,
  output logic                rx_accept
);
  localparam int FLD_W = DATA_W / 2;
  localparam logic [FLD_W-1:0] CODE_RD = FLD_W'(0);
  localparam logic [FLD_W-1:0] CODE_WR = FLD_W'(1);
  localparam logic [DATA_W-1:0] FTR_OK  = DATA_W'(0);
  localparam logic [DATA_W-1:0] FTR_BAD = DATA_W'(1);

  typedef enum logic [2:0] {
    S_IDLE, S_TX_HDR, S_TX_DAT, S_RX_HDR, S_RX_DAT, S_RX_FTR
  } state_t;

  state_t            state;
  logic [DATA_W-1:0] hdr_q, wdata_q, rdata_acc;
  logic              is_wr, perr_acc;
  logic              rx_fire, beat_bad;

  assign cmd_ready = (state == S_IDLE);
  assign tx_valid  = (state == S_TX_HDR) || (state == S_TX_DAT);
  assign tx_first  = (state == S_TX_HDR);
  assign tx_last   = ((state == S_TX_HDR) && !is_wr) || (state == S_TX_DAT);
  assign tx_data   = (state == S_TX_DAT) ? wdata_q :
                     (state == S_TX_HDR) ? hdr_q : '0;
  assign rx_accept = (state == S_RX_HDR) || (state == S_RX_DAT) || (state == S_RX_FTR);
  assign rx_fire   = rx_accept && rx_valid;

  always_comb begin
    case (state)
      S_RX_HDR: beat_bad = !rx_first || rx_last || (rx_data != hdr_q);
      S_RX_DAT: beat_bad = rx_first || rx_last;
      S_RX_FTR: beat_bad = rx_first || !rx_last ||
                           ((rx_data != FTR_OK) && (rx_data != FTR_BAD));
      default:  beat_bad = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state         <= S_IDLE;
      hdr_q         <= '0;
      wdata_q       <= '0;
      rdata_acc     <= '0;
      is_wr         <= 1'b0;
      perr_acc      <= 1'b0;
      rsp_done      <= 1'b0;
      rsp_rdata     <= '0;
      rsp_err       <= 1'b0;
      rsp_proto_err <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          hdr_q     <= {cmd_addr, cmd_write ? CODE_WR : CODE_RD};
          wdata_q   <= cmd_wdata;
          is_wr     <= cmd_write;
          rdata_acc <= '0;
          perr_acc  <= 1'b0;
          state     <= S_TX_HDR;
        end
        S_TX_HDR: if (tx_accept) state <= is_wr ? S_TX_DAT : S_RX_HDR;
        S_TX_DAT: if (tx_accept) state <= S_RX_HDR;
        default: if (rx_fire) begin
          perr_acc <= perr_acc | beat_bad;
          if (state == S_RX_DAT) rdata_acc <= rx_data;
          if (rx_last) begin
            rsp_done      <= 1'b1;
            rsp_proto_err <= perr_acc | beat_bad;
            rsp_err       <= (state == S_RX_FTR) && (rx_data == FTR_BAD);
            rsp_rdata     <= (state == S_RX_DAT) ? rx_data : rdata_acc;
            state         <= S_IDLE;
          end else if (state == S_RX_HDR) begin
            state <= is_wr ? S_RX_FTR : S_RX_DAT;
          end else if (state == S_RX_DAT) begin
            state <= S_RX_FTR;
          end
        end
      endcase
    end
  end
endmodule

module regjob_initiator_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cmd_valid,
  input logic                cmd_ready,
  input logic                rsp_done,
  input logic                rsp_proto_err,
  input logic [DATA_W-1:0]   tx_data,
  input logic                tx_valid,
  input logic                tx_first,
  input logic                tx_last,
  input logic                tx_accept,
  input logic                rx_valid,
  input logic                rx_last,
  input logic                rx_accept
);
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_accept |=> tx_valid && $stable(tx_data) && $stable(tx_first) && $stable(tx_last)); // R5
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_first || tx_last) |-> tx_valid); // R3
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !tx_valid && !rx_accept); // R6
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_valid && rx_accept)); // R7
  AST_CMD_STARTS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> !cmd_ready && tx_valid && tx_first); // R6
  AST_WRITE_DATA_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_accept && tx_first && !tx_last |=> tx_valid && !tx_first && tx_last); // R4
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    rx_accept && rx_valid && rx_last |=> rsp_done && cmd_ready); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done); // R11
  AST_PERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_proto_err) |-> rsp_done); // R10
endmodule

bind regjob_initiator regjob_initiator_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_regjob_initiator.sv
module tb_regjob_initiator;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0, cmd_ready, cmd_write = 1'b0;
  logic [3:0] cmd_addr = '0;
  logic [7:0] cmd_wdata = '0;
  logic       rsp_done, rsp_err, rsp_proto_err;
  logic [7:0] rsp_rdata;
  logic [7:0] tx_data;
  logic       tx_valid, tx_first, tx_last, tx_accept = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_valid = 1'b0, rx_first = 1'b0, rx_last = 1'b0, rx_accept;

  int checks = 0;
  int errors = 0;
  logic [7:0] mem [8];

  regjob_initiator dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic rx_beat(input logic [7:0] d, input logic f, input logic l, input int gap);
    for (int g = 0; g < gap; g++) @(negedge clk);
    rx_data = d; rx_first = f; rx_last = l; rx_valid = 1'b1;
    @(negedge clk);
    rx_valid = 1'b0; rx_first = 1'b0; rx_last = 1'b0;
  endtask

  task automatic tx_stall(input logic [7:0] exp_d, input logic ef, input logic el,
                          input int stall, input logic [3:0] a);
    chk(tx_valid && tx_first == ef && tx_last == el, "R3", "beat flags",
        {tx_valid, tx_first, tx_last}, {1'b1, ef, el});
    chk(tx_data == exp_d, "R2", "beat data", tx_data, exp_d);
    chk(!rx_accept, "R7", "rx_accept during send", rx_accept, 0);
    for (int s = 0; s < stall; s++) begin
      cmd_valid = 1'b1; cmd_addr = ~a; cmd_write = ~cmd_write; cmd_wdata = 8'hEE;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(tx_valid && tx_data == exp_d && tx_first == ef && tx_last == el, "R5", "hold while stalled",
          {tx_valid, tx_first, tx_last, tx_data}, {1'b1, ef, el, exp_d});
      chk(!cmd_ready, "R6", "busy during job", cmd_ready, 0);
    end
    tx_accept = 1'b1;
    @(negedge clk);
    tx_accept = 1'b0;
  endtask

  // mode: 0 normal, 1 bad echo, 2 odd footer, 3 early last
  task automatic do_job(input logic wr, input logic [3:0] a, input logic [7:0] d,
                        input int stall, input int mode);
    logic [7:0] hdr, rd, ft;
    logic exp_err, exp_perr;
    logic [7:0] exp_rd;
    hdr = {a, 3'b000, wr};
    rd  = (a <= 7) ? mem[a[2:0]] : 8'h00;
    ft  = (a <= 7) ? 8'h00 : 8'h01;
    chk(cmd_ready, "R6", "ready when idle", cmd_ready, 1);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R6", "busy after command", cmd_ready, 0);
    if (wr) begin
      tx_stall(hdr, 1'b1, 1'b0, stall, a);   // R4 header beat
      tx_stall(d, 1'b0, 1'b1, stall % 2, a); // R4 data beat
    end else begin
      tx_stall(hdr, 1'b1, 1'b1, stall, a);   // R3 single beat
    end
    chk(rx_accept && !tx_valid, "R7", "waiting for ack", {rx_accept, tx_valid}, 2'b10);
    exp_perr = (mode != 0);
    exp_err = 1'b0;
    exp_rd = 8'h00;
    if (mode == 3) begin
      rx_beat(hdr, 1'b1, 1'b1, 0);
    end else begin
      rx_beat((mode == 1) ? (hdr ^ 8'h20) : hdr, 1'b1, 1'b0, stall % 2);
      if (!wr) begin
        rx_beat(rd, 1'b0, 1'b0, stall % 3);
        exp_rd = rd;
      end
      if (mode == 2) rx_beat(8'h05, 1'b0, 1'b1, 0);
      else begin
        rx_beat(ft, 1'b0, 1'b1, stall % 2);
        exp_err = ft[0];
      end
      if (wr && a <= 7 && mode == 0) mem[a[2:0]] = d;
    end
    chk(rsp_done, "R8", "done after last beat", rsp_done, 1);
    chk(cmd_ready, "R11", "ready with done", cmd_ready, 1);
    chk(rsp_rdata == exp_rd, "R8", "read data", rsp_rdata, exp_rd);
    chk(rsp_err == exp_err, "R9", "footer error", rsp_err, exp_err);
    chk(rsp_proto_err == exp_perr, "R10", "protocol error", rsp_proto_err, exp_perr);
    @(negedge clk);
    chk(!rsp_done, "R11", "done single pulse", rsp_done, 0);
    chk(!rx_accept && !tx_valid, "R7", "quiet after job", {rx_accept, tx_valid}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mem[i] = 8'(8'h30 + i * 7);
    @(negedge clk);
    chk(!tx_valid && !tx_first && !tx_last && !rx_accept && !rsp_done && cmd_ready, "R1",
        "reset state", {tx_valid, tx_first, tx_last, rx_accept, rsp_done, cmd_ready}, 6'b000001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // sweep: writes then reads over all addresses
    for (int a = 0; a < 16; a++) do_job(1'b1, 4'(a), 8'(8'h81 + a * 13), a % 3, 0);
    for (int a = 0; a < 16; a++) do_job(1'b0, 4'(a), 8'h00, (a + 1) % 3, 0);
    // malformed acknowledges
    do_job(1'b0, 4'd2, 8'h00, 1, 1);
    do_job(1'b1, 4'd5, 8'h11, 0, 1);
    do_job(1'b0, 4'd3, 8'h00, 0, 2);
    do_job(1'b1, 4'd9, 8'h22, 2, 3);
    do_job(1'b0, 4'd6, 8'h00, 0, 3);
    // recovery after errors
    do_job(1'b0, 4'd5, 8'h00, 0, 0);
    // reset in the middle of a job
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 4'd1; cmd_wdata = 8'h5A;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(tx_valid, "R6", "frame started before reset", tx_valid, 1);
    #1 rst_n = 1'b0;
    #1 chk(!tx_valid && !tx_first && !tx_last && !rx_accept && cmd_ready, "R1", "async reset mid job",
           {tx_valid, tx_first, tx_last, rx_accept, cmd_ready}, 5'b00001);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    do_job(1'b0, 4'd1, 8'h00, 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule